// File: doc/BRIEF.md
# Exponent-Binned Partial-Sum Accumulator

This block sums a long stream of small floating-point operands (eight-bit, one sign bit, four exponent bits, three mantissa bits by default) without ever aligning or rounding them on the way in. Each operand's significand, with its hidden leading one restored and negated for a negative sign, is added to an exact two's-complement integer register chosen by the operand's exponent. The register bank therefore holds the whole sum, split by binary weight. A separate reconstruction unit reads the bins through an index port after the stream ends, and it performs the one final alignment and rounding step.

A grouping parameter lets several neighbouring exponents share one wider bin. The high exponent bits then pick the bin, and the low exponent bits shift the significand left before the add. The bin count halves for each grouping bit, and each bin grows by the shift range. Updates run through a two-stage read-modify-write. A forwarding path covers an operand that lands in the bin still being written. A synchronous clear empties the bank between sums.

Top module: `expbin_accum`

## Requirements
- R1: The operand holds the sign in bit 7, the exponent field in bits 6..3 and the mantissa in bits 2..0 (default widths). For a valid operand with a nonzero exponent e and mantissa m, in the ungrouped configuration, bin e changes by +(8+m), or by -(8+m) when the sign bit is 1.
- R2: Bins are exact signed two's-complement integers. After any mix of additions the bin value equals the exact integer sum of its contributions, with no rounding or truncation.
- R3: With GROUP_W grouping bits (GROUP_W=1 is tested), an operand goes to bin e>>GROUP_W. Its contribution is (8+m) shifted left by the low GROUP_W exponent bits, and it is negated when the sign is 1.
- R4: A valid operand whose exponent field is zero changes no bin.
- R5: Operands presented on back-to-back cycles to the same bin are all counted, and no update is lost.
- R6: While clear is high, every bin becomes zero at the next edge. An operand presented in the same cycle is discarded, and so is an operand still being written from the previous cycle.
- R7: After a reset every bin reads zero.
- R8: rdData shows bin rdIdx combinationally. An operand presented before clock edge k is visible on rdData after edge k+1, and it is not yet visible between edges k and k+1.
- R9: A bin receives no overflow from up to 2^SUM_LOG (256) operands of the largest magnitude and the same sign.
- R10: Operand values present while inValid is low change no bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear of all bins; overrides any input |
| inValid | input | 1 | Qualifies inOperand |
| inOperand | input | 1+EXP_W+MAN_W | Sign, exponent, mantissa (MSB to LSB) |
| rdIdx | input | EXP_W-GROUP_W | Bin index to read |
| rdData | output | BIN_W | Signed content of bin rdIdx |

## Verification
The bench drives one ungrouped and one grouped instance with the same stimulus. It compares every bin against an arithmetic model. First, a full sweep of all 256 operand codes in ascending order, then in descending order, puts long back-to-back runs into each bin. This tells forwarding faults apart from decode faults, and zero-exponent codes sit inside the sweep. Next, a pseudo-random stream with gaps in the valid signal separates gating faults from address faults. Finally, runs of 256 largest-magnitude operands of each sign expose a bin that is too narrow. Clears with operands in flight, and a single-operand latency probe, fix the timing of the update and of the discard.

// File: rtl/expbin_pkg.sv
package expbin_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // capture decoded operand into the update stage
    logic write;  // commit the update stage into its bin
    logic clear;  // zero every bin
  } accStrobe_t;
endpackage

// File: rtl/expbin_ctrl.sv
module expbin_ctrl
  import expbin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inExpZero,
  input  logic       clear,
  output accStrobe_t stb
);
  logic pendQ;

  always_comb begin
    stb.clear = clear;
    stb.load  = inValid && !inExpZero && !clear;
    stb.write = pendQ && !clear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= stb.load;
  end

  // R4
  zero_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inExpZero) |=> !stb.write);

  // R6
  clear_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !stb.write);

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !stb.write);
endmodule

// File: rtl/expbin_datapath.sv
module expbin_datapath
  import expbin_pkg::*;
#(
  parameter int EXP_W   = 4,
  parameter int MAN_W   = 3,
  parameter int GROUP_W = 0,
  parameter int SUM_LOG = 8,
  localparam int OP_W   = 1 + EXP_W + MAN_W,
  localparam int IDX_W  = EXP_W - GROUP_W,
  localparam int NBINS  = 1 << IDX_W,
  localparam int SH_W   = (GROUP_W > 0) ? GROUP_W : 1,
  localparam int MAG_W  = MAN_W + 1 + (1 << GROUP_W) - 1,
  localparam int BIN_W  = MAG_W + SUM_LOG + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  accStrobe_t       stb,
  input  logic [OP_W-1:0]  inOperand,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [BIN_W-1:0] rdData
);
  logic             signBit;
  logic [EXP_W-1:0] expF;
  logic [MAN_W-1:0] manF;
  logic [IDX_W-1:0] inIdx;
  logic [SH_W-1:0]  shAmt;
  logic [BIN_W-1:0] magV, addV, rdOld, binNext;

  logic [IDX_W-1:0] s1Idx;
  logic [BIN_W-1:0] s1Add, s1Read;
  logic [NBINS-1:0][BIN_W-1:0] binQ;

  assign signBit = inOperand[OP_W-1];
  assign expF    = inOperand[OP_W-2 -: EXP_W];
  assign manF    = inOperand[MAN_W-1:0];

  generate
    if (GROUP_W == 0) begin : g_flat
      assign inIdx = expF;
      assign shAmt = '0;
    end else begin : g_grp
      assign inIdx = expF[EXP_W-1:GROUP_W];
      assign shAmt = expF[GROUP_W-1:0];
    end
  endgenerate

  // Restore hidden one, apply group shift, then sign.
  assign magV = {{(BIN_W-MAN_W-1){1'b0}}, 1'b1, manF} << shAmt;
  assign addV = signBit ? (~magV + 1'b1) : magV;

  // Forward the value being written when the new operand hits the same bin.
  assign rdOld   = (stb.write && (s1Idx == inIdx)) ? binNext : binQ[inIdx];
  assign binNext = s1Read + s1Add;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Idx  <= '0;
      s1Add  <= '0;
      s1Read <= '0;
    end else if (stb.load) begin
      s1Idx  <= inIdx;
      s1Add  <= addV;
      s1Read <= rdOld;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          binQ <= '0;
    else if (stb.clear) binQ <= '0;
    else if (stb.write) binQ[s1Idx] <= binNext;
  end

  assign rdData = binQ[rdIdx];

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.write && (s1Read[BIN_W-1] == s1Add[BIN_W-1]))
      |-> (binNext[BIN_W-1] == s1Read[BIN_W-1]));

  // R5
  bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.write |-> (s1Read == binQ[s1Idx]));

  // R1
  nonzero_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.write |-> (binNext != s1Read));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (binQ == '0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.write && !stb.clear) |=> $stable(binQ));
endmodule

// File: rtl/expbin_accum.sv
module expbin_accum
  import expbin_pkg::*;
#(
  parameter int EXP_W   = 4,
  parameter int MAN_W   = 3,
  parameter int GROUP_W = 0,
  parameter int SUM_LOG = 8,
  localparam int OP_W   = 1 + EXP_W + MAN_W,
  localparam int IDX_W  = EXP_W - GROUP_W,
  localparam int MAG_W  = MAN_W + 1 + (1 << GROUP_W) - 1,
  localparam int BIN_W  = MAG_W + SUM_LOG + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             inValid,
  input  logic [OP_W-1:0]  inOperand,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [BIN_W-1:0] rdData
);
  accStrobe_t stb;
  logic       inExpZero;

  assign inExpZero = (inOperand[OP_W-2 -: EXP_W] == '0);

  expbin_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inExpZero (inExpZero),
    .clear     (clear),
    .stb       (stb)
  );

  expbin_datapath #(
    .EXP_W   (EXP_W),
    .MAN_W   (MAN_W),
    .GROUP_W (GROUP_W),
    .SUM_LOG (SUM_LOG)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .inOperand (inOperand),
    .rdIdx     (rdIdx),
    .rdData    (rdData)
  );
endmodule

// File: tb/expbin_accum_bench.sv
`timescale 1ns/1ps
module expbin_accum_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inOperand = '0;
  logic [3:0]  rdIdx0 = '0;
  logic [2:0]  rdIdx1 = '0;
  logic [12:0] rdData0;
  logic [13:0] rdData1;

  int errors = 0;
  int checks = 0;
  int ref0 [16];
  int ref1 [8];
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  expbin_accum #(.GROUP_W(0)) u_expbin_accum (
    .clk(clk), .rstN(rstN), .clear(clear), .inValid(inValid),
    .inOperand(inOperand), .rdIdx(rdIdx0), .rdData(rdData0));

  expbin_accum #(.GROUP_W(1)) u_expbin_accum_g1 (
    .clk(clk), .rstN(rstN), .clear(clear), .inValid(inValid),
    .inOperand(inOperand), .rdIdx(rdIdx1), .rdData(rdData1));

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelZero();
    for (int i = 0; i < 16; i++) ref0[i] = 0;
    for (int i = 0; i < 8; i++)  ref1[i] = 0;
  endtask

  // One cycle of stimulus; model follows the requirements.
  task automatic push(input logic v, input logic [7:0] op, input logic clr);
    @(negedge clk);
    inValid = v; inOperand = op; clear = clr;
    @(posedge clk);
    if (clr) modelZero();
    else if (v && op[6:3] != 0) begin
      int mag = 8 + op[2:0];
      int e = op[6:3];
      ref0[e]    += op[7] ? -mag : mag;
      ref1[e>>1] += op[7] ? -(mag << (e & 1)) : (mag << (e & 1));
    end
  endtask

  task automatic idle2();
    push(1'b0, 8'hA5, 1'b0);
    push(1'b0, 8'h5A, 1'b0);
  endtask

  task automatic checkAll(input string req, input string what);
    for (int i = 0; i < 16; i++) begin
      rdIdx0 = i[3:0]; #0.1;
      check($signed(rdData0), ref0[i], req, {what, " flat"});
    end
    for (int i = 0; i < 8; i++) begin
      rdIdx1 = i[2:0]; #0.1;
      check($signed(rdData1), ref1[i], req, {what, " grouped"});
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lcg;
    modelZero();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    checkAll("R7", "after reset");

    // R8 latency: not visible after one edge, visible after two
    push(1'b1, {1'b0, 4'd5, 3'd3}, 1'b0);
    @(negedge clk); inValid = 1'b0; rdIdx0 = 4'd5; #0.1;
    check($signed(rdData0), 0, "R8", "one edge after input");
    @(posedge clk); #1;
    check($signed(rdData0), 11, "R8", "two edges after input");
    @(negedge clk); rdIdx1 = 3'd2; #0.1;
    check($signed(rdData1), 22, "R3", "grouped shift by odd exponent");

    // R6: clear with operand in flight and same-cycle operand
    push(1'b1, 8'h47, 1'b0);
    push(1'b1, 8'h47, 1'b1);
    idle2();
    checkAll("R6", "clear discards in-flight");

    // R1 R2 R4 R5 R3: ascending sweep of every code, back-to-back
    for (int c = 0; c < 256; c++) push(1'b1, c[7:0], 1'b0);
    idle2();
    checkAll("R5", "ascending sweep");
    for (int c = 255; c >= 0; c--) push(1'b1, c[7:0], 1'b0);
    idle2();
    checkAll("R1", "descending sweep");

    // R4: only zero-exponent codes
    for (int c = 0; c < 16; c++) push(1'b1, {c[3], 4'd0, c[2:0]}, 1'b0);
    idle2();
    checkAll("R4", "zero exponent");

    // R10 R2: pseudo-random stream with gaps in valid
    push(1'b0, 8'h00, 1'b1);
    lcg = 12345;
    for (int k = 0; k < 400; k++) begin
      lcg = lcg * 1103515245 + 12345;
      push(lcg[20] | lcg[21], lcg[29:22], 1'b0);
    end
    idle2();
    checkAll("R10", "gapped random stream");

    // R9: 256 largest negative into one bin, 256 largest positive
    push(1'b0, 8'h00, 1'b1);
    for (int k = 0; k < 256; k++) push(1'b1, 8'hFF, 1'b0);
    for (int k = 0; k < 256; k++) push(1'b1, 8'h7F, 1'b0);
    for (int k = 0; k < 256; k++) push(1'b1, 8'hF7, 1'b0);
    idle2();
    checkAll("R9", "full-scale runs");

    // R6: plain clear then accumulation resumes
    push(1'b0, 8'h00, 1'b1);
    push(1'b1, 8'h09, 1'b0);
    idle2();
    checkAll("R6", "after clear");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule